// File: doc/BRIEF.md
# Timer Input Capture Unit

This block watches a single asynchronous input pin and, when a chosen event is seen on it, copies the current value of a free-running 16-bit timer into a 16-bit capture register. The event is one of four kinds: any falling edge, any rising edge, each fourth rising edge, or each sixteenth rising edge. Every capture raises a sticky interrupt flag that stays up until software pulses a clear strobe.

The pin is brought into the clock domain by a two-flop synchronizer before edge detection. A rising-edge prescaler counter serves the two divided modes. It returns to zero only while the unit is off or set to a non-capture code. A direct switch between two capture modes keeps the count, and the switch itself raises the flag without a capture. To change mode cleanly, software writes the off code first and then the new mode.

Top module: `cap_unit`

## Requirements
- R1: While rst_ni is low, cap_o reads 0 and flag_o reads 0, and the prescaler count is zero.
- R2: With mode_i = 4'b0100, each falling edge of pin_i loads timer_i into cap_o. A pin change made before clock edge k is captured at edge k+2: the timer_i value present at that edge is stored, and flag_o rises at the same edge.
- R3: With mode_i = 4'b0101, each rising edge of pin_i loads timer_i into cap_o, with the same latency as R2.
- R4: With mode_i = 4'b0110, only the 4th, 8th, ... rising edge counted since the prescaler was last cleared produces a capture.
- R5: With mode_i = 4'b0111, only the 16th, 32nd, ... rising edge counted since the prescaler was last cleared produces a capture.
- R6: A new capture replaces cap_o even when flag_o is still set from an earlier capture.
- R7: flag_o stays set until a cycle with flag_clr_i high, and it is 0 after that edge if no capture or mode switch occurs in the same cycle.
- R8: If a capture and flag_clr_i fall on the same clock edge, flag_o is 1 after that edge.
- R9: Mode code 4'b0000 (off) and every code whose upper two bits are not 2'b01 (non-capture) make no capture and set no flag. They clear the prescaler count, so that after a return to a divided mode a full 4 or 16 rising edges are needed.
- R10: A direct change from one capture mode to another keeps the prescaler count, so the first divided capture after it may come after fewer edges.
- R11: One clock edge after mode_i changes from one capture code to a different capture code, flag_o is 1 and cap_o is unchanged. Changes to or from a non-capture code set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 1 | Asynchronous capture input pin |
| timer_i | input | 16 | Free-running timer value |
| mode_i | input | 4 | Capture mode code |
| flag_clr_i | input | 1 | Strobe that clears the interrupt flag |
| cap_o | output | 16 | Captured timer value |
| flag_o | output | 1 | Sticky capture interrupt flag |

## Verification
Each mode gets a pulse train one pulse short of its capture point and then one that reaches it. This separates the falling and rising choices and shows that the divide-by-4 and divide-by-16 counts are exact. A timer value that changes on every clock around a single edge pins down the two-cycle latency. Back-to-back captures without a clear show the overwrite. A clear strobe placed on the capture edge shows that setting the flag wins. Three count-history cases are compared: a stop at the off code before a return, a direct switch from divide-by-16 to divide-by-4, and a switch between the two single-edge modes. They tell a cleared prescaler from a kept one, and a true capture from a switch-only flag.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MODE_OFF   = 4'b0000,
    MODE_FALL  = 4'b0100,
    MODE_RISE  = 4'b0101,
    MODE_DIV4  = 4'b0110,
    MODE_DIV16 = 4'b0111
  } cap_mode_e;

  function automatic logic is_capture(logic [MODE_W-1:0] m);
    return m[3:2] == 2'b01;
  endfunction
endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  // STAGES synchronizer flops plus one history flop for edge detection
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];
endmodule

// File: rtl/cap_presc.sv
module cap_presc
  import cap_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              rise_i,
  input  logic              fall_i,
  output logic              evt_o,
  output logic [CNT_W-1:0]  cnt_o
);
  localparam int SMALL_W = CNT_W / 2;

  logic [CNT_W-1:0] cnt_q;
  logic             active;

  assign active = is_capture(mode_i);

  // count survives direct capture-to-capture switches
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else if (rise_i)  cnt_q <= cnt_q + 1'b1;
  end

  always_comb begin
    case (mode_i)
      MODE_FALL:  evt_o = fall_i;
      MODE_RISE:  evt_o = rise_i;
      MODE_DIV4:  evt_o = rise_i & (&cnt_q[SMALL_W-1:0]);
      MODE_DIV16: evt_o = rise_i & (&cnt_q);
      default:    evt_o = 1'b0;
    endcase
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
#(
  parameter int TMR_W  = 16,
  parameter int SYNC_N = 2,
  parameter int PRE_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pin_i,
  input  logic [TMR_W-1:0]  timer_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              flag_clr_i,
  output logic [TMR_W-1:0]  cap_o,
  output logic              flag_o
);
  logic [MODE_W-1:0] mode_q;
  logic              rise, fall;
  logic              cap_evt;
  logic [PRE_W-1:0]  presc_cnt;
  logic              mode_swap;
  logic [TMR_W-1:0]  cap_q;
  logic              flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_OFF;
    else         mode_q <= mode_i;
  end

  // capture-to-capture change: flag only, no load
  assign mode_swap = is_capture(mode_i) & is_capture(mode_q) & (mode_i != mode_q);

  cap_sync #(.STAGES(SYNC_N)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .pin_i (pin_i),
    .rise_o(rise),
    .fall_o(fall)
  );

  cap_presc #(.CNT_W(PRE_W)) i_presc (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_q),
    .rise_i(rise),
    .fall_i(fall),
    .evt_o (cap_evt),
    .cnt_o (presc_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cap_q <= '0;
    else if (cap_evt) cap_q <= timer_i;
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    flag_q <= 1'b0;
    else if (cap_evt || mode_swap)  flag_q <= 1'b1;
    else if (flag_clr_i)            flag_q <= 1'b0;
  end

  assign cap_o  = cap_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/cap_unit_chk.sv
module cap_unit_chk
  import cap_pkg::*;
#(
  parameter int TMR_W = 16,
  parameter int PRE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [MODE_W-1:0] mode_i,
  input logic [MODE_W-1:0] mode_q,
  input logic              flag_clr_i,
  input logic              evt,
  input logic [PRE_W-1:0]  cnt,
  input logic [TMR_W-1:0]  cap_o,
  input logic              flag_o
);
  logic swap;
  assign swap = is_capture(mode_i) && is_capture(mode_q) && (mode_i != mode_q);

  a_r6_load_sets_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cap_o) |-> flag_o);

  a_r7_flag_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_o && !flag_clr_i |=> flag_o);

  a_r7_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_clr_i && !evt && !swap |=> !flag_o);

  a_r8_event_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt |=> flag_o);

  a_r9_idle_no_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_capture(mode_q) |=> $stable(cap_o));

  a_r9_presc_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !is_capture(mode_q) |=> cnt == '0);

  a_r11_swap_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap && !evt |=> flag_o && $stable(cap_o));
endmodule

bind cap_unit cap_unit_chk #(.TMR_W(TMR_W), .PRE_W(PRE_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .mode_q    (mode_q),
  .flag_clr_i(flag_clr_i),
  .evt       (cap_evt),
  .cnt       (presc_cnt),
  .cap_o     (cap_o),
  .flag_o    (flag_o)
);

// File: tb/test_cap_unit.sv
module test_cap_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        pin_i = 1'b0;
  logic [15:0] timer_i = '0;
  logic [3:0]  mode_i = 4'b0000;
  logic        flag_clr_i = 1'b0;
  logic [15:0] cap_o;
  logic        flag_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] cap_ref = '0;

  always #10 clk_i = ~clk_i;

  cap_unit i_cap_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_i), .timer_i(timer_i),
    .mode_i(mode_i), .flag_clr_i(flag_clr_i), .cap_o(cap_o), .flag_o(flag_o)
  );

  typedef struct packed {
    logic [3:0]  mode;
    logic [7:0]  pulses;
    logic [15:0] tmr;
    logic        exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{4'b0100, 8'd1,  16'h1111, 1'b1},
    '{4'b0101, 8'd1,  16'h2222, 1'b1},
    '{4'b0110, 8'd3,  16'h3333, 1'b0},
    '{4'b0110, 8'd4,  16'h4444, 1'b1},
    '{4'b0111, 8'd15, 16'h5555, 1'b0},
    '{4'b0111, 8'd16, 16'h6666, 1'b1},
    '{4'b0000, 8'd2,  16'h7777, 1'b0},
    '{4'b0011, 8'd3,  16'h8888, 1'b0},
    '{4'b1101, 8'd2,  16'h9999, 1'b0},
    '{4'b0100, 8'd0,  16'haaaa, 1'b0}
  };

  function automatic string tag_of(logic [3:0] m);
    case (m)
      4'b0100: return "R2";
      4'b0101: return "R3";
      4'b0110: return "R4";
      4'b0111: return "R5";
      default: return "R9";
    endcase
  endfunction

  task automatic tick(int n = 1);
    repeat (n) begin
      @(posedge clk_i);
      @(negedge clk_i);
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      pin_i = 1'b1; tick(3);
      pin_i = 1'b0; tick(3);
    end
  endtask

  task automatic clr_flag();
    flag_clr_i = 1'b1; tick();
    flag_clr_i = 1'b0;
  endtask

  task automatic set_mode_clean(logic [3:0] m);
    mode_i = 4'b0000; tick(2);
    mode_i = m;       tick(2);
    clr_flag();
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1 reset state
    tick(3);
    chk("R1 cap", cap_o, 0);
    chk("R1 flag", flag_o, 0);
    rst_ni = 1'b1;
    tick(2);
    chk("R1 flag after release", flag_o, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      set_mode_clean(VECS[v].mode);
      timer_i = VECS[v].tmr;
      pulse(int'(VECS[v].pulses));
      tick(4);
      if (VECS[v].exp) cap_ref = VECS[v].tmr;
      chk({tag_of(VECS[v].mode), " flag"}, flag_o, VECS[v].exp);
      chk({tag_of(VECS[v].mode), " cap"}, cap_o, cap_ref);
    end

    // R3 latency: timer value at the third edge after the pin change
    set_mode_clean(4'b0101);
    pin_i = 1'b1; timer_i = 16'h0a01; tick();
    timer_i = 16'h0a02; tick();
    chk("R3 no flag yet", flag_o, 0);
    timer_i = 16'h0a03; tick();
    chk("R3 latency flag", flag_o, 1);
    chk("R3 latency cap", cap_o, 16'h0a03);
    pin_i = 1'b0; tick(3);

    // R8 clear strobe on the capture edge, flag already set
    pin_i = 1'b1; timer_i = 16'h0b0b; tick(2);
    flag_clr_i = 1'b1; tick();
    flag_clr_i = 1'b0;
    chk("R8 set wins flag", flag_o, 1);
    chk("R8 cap", cap_o, 16'h0b0b);
    pin_i = 1'b0; tick(3);

    // R7 sticky then cleared
    tick(10);
    chk("R7 sticky", flag_o, 1);
    clr_flag();
    chk("R7 cleared", flag_o, 0);
    tick(5);
    chk("R7 stays clear", flag_o, 0);

    // R6 overwrite without clearing
    timer_i = 16'h0c01; pulse(1);
    timer_i = 16'h0c02; pulse(1);
    tick(2);
    chk("R6 overwrite cap", cap_o, 16'h0c02);
    chk("R6 flag", flag_o, 1);

    // R11 and R10: direct switch from /16 to /4 after 3 edges
    set_mode_clean(4'b0111);
    timer_i = 16'h0d0d; pulse(3); tick(2);
    chk("R10 no capture at 3 of 16", flag_o, 0);
    mode_i = 4'b0110; tick();
    chk("R11 switch flag", flag_o, 1);
    chk("R11 switch cap kept", cap_o, 16'h0c02);
    clr_flag();
    chk("R11 flag cleared", flag_o, 0);
    timer_i = 16'h0e0e; pulse(1); tick(2);
    chk("R10 early capture flag", flag_o, 1);
    chk("R10 early capture cap", cap_o, 16'h0e0e);

    // R11 between single-edge modes
    set_mode_clean(4'b0100);
    mode_i = 4'b0101; tick();
    chk("R11 fall->rise flag", flag_o, 1);
    chk("R11 fall->rise cap", cap_o, 16'h0e0e);

    // R9 off clears prescaler; off transitions raise no flag
    set_mode_clean(4'b0110);
    timer_i = 16'h0f0f; pulse(3); tick(2);
    chk("R9 /4 partial", flag_o, 0);
    mode_i = 4'b0000; tick(2);
    chk("R9 to off no flag", flag_o, 0);
    mode_i = 4'b0110; tick(2);
    chk("R9 from off no flag", flag_o, 0);
    pulse(1); tick(2);
    chk("R9 count restarted", flag_o, 0);
    pulse(3); tick(2);
    chk("R9 full four flag", flag_o, 1);
    chk("R9 full four cap", cap_o, 16'h0f0f);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule